// File: doc/BRIEF.md
# Stereo PDM to PCM Decimator

This block turns a single pulse-density-modulated data line that carries two microphones into two streams of signed 16-bit PCM samples. A clock generator elsewhere produces the PDM bit clock and hands this block two single-cycle strobes in the system clock domain: one for the rising edge and one for the falling edge of that bit clock. The bit present at the rising edge belongs to the left channel. The bit present at the falling edge belongs to the right channel.

Each channel passes through a third-order sinc (CIC) decimator split into two downsampling rounds. The first round reduces the rate by 8 or 16, chosen by a ratio select input. The second round always reduces it by 8. The overall ratio is therefore 64 or 128 PDM clock periods per PCM sample. Both channels share one phase counter. A completed stereo pair is marked by one valid pulse. The full-precision result is scaled to the 16-bit range according to the selected ratio and then saturated. After the block is enabled, or after the ratio changes, the first outputs are held back until the comb delay lines have been refilled.

Top module: `pdm_stereo_decim`

## Requirements
- R1: While reset is held, and after it is released, both PCM outputs read 0 and the valid output is low until the first sample is produced.
- R2: The left channel takes the data bit present on a cycle with the rise strobe high. The right channel takes the data bit present on a cycle with the fall strobe high. One PDM period is complete at its fall strobe.
- R3: A data bit of 1 counts as +1 and a bit of 0 counts as -1. For an input in which every 8 consecutive bits of a channel hold k ones, the settled output of that channel is (2k-8)*4096, saturated to 32767. Outputs are two's complement.
- R4: With ratio_sel=0 the overall ratio is 64 (first round 8). With ratio_sel=1 it is 128 (first round 16). Once running, valid pulses come exactly 64 or 128 PDM periods apart.
- R5: valid is high for exactly one system cycle per output period, and it qualifies the left and right samples together.
- R6: After enable rises, or after ratio_sel changes while enabled, the first two output periods produce no valid. The first valid appears 3 system cycles after the fall strobe of PDM period number 3*ratio, counted from that event.
- R7: While enable is low, strobes are ignored, no valid is produced, and all filter state is cleared.
- R8: Full-scale input saturates. All ones gives 32767 and all zeros gives -32768.
- R9: The PCM outputs change only in a cycle where valid is high. At all other times they hold their last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears the filters |
| pdm_dat | input | 1 | PDM data line shared by both channels |
| pdm_rise | input | 1 | One-cycle strobe at the PDM clock rising edge (left bit) |
| pdm_fall | input | 1 | One-cycle strobe at the PDM clock falling edge (right bit) |
| ratio_sel | input | 1 | 0: ratio 64, 1: ratio 128 |
| pcm_left | output | 16 | Left PCM sample, two's complement |
| pcm_right | output | 16 | Right PCM sample, two's complement |
| pcm_valid | output | 1 | One-cycle pulse marking a new stereo pair |

## Verification
The bench builds the block with its default parameters: first-round factors 8 and 16, a second round of 8, and 16-bit output. With these values both overall ratios are used, the scaling makes all-ones and all-zeros land exactly on the saturation edges, and every periodic 8-bit pattern produces an exact DC code. The warm-up counts of 192 and 384 PDM periods, and the 64- and 128-period output spacing, are therefore checked against exact numbers. Random pairs of 8-bit density patterns on the two channels, mixed with ratio switches and enable drops, check the channel separation and the DC gain at both ratios.

// File: rtl/pdm_dec_pkg.sv
package pdm_dec_pkg;

    // Overall decimation choice carried by the ratio select input.
    typedef enum logic {
        RATIO_64  = 1'b0,
        RATIO_128 = 1'b1
    } ratio_e;

    // Bits of one PDM period after the edge demultiplexer.
    typedef struct packed {
        logic left;
        logic right;
    } pdm_pair_t;

    // Right shift that maps the full-scale CIC result onto a signed pcm_w word.
    function automatic int pcm_shift(input int log2_total, input int pcm_w);
        return 3 * log2_total - (pcm_w - 1);
    endfunction

endpackage

// File: rtl/pdm_edge_split.sv
module pdm_edge_split
    import pdm_dec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      pdm_dat,
    input  logic      pdm_rise,
    input  logic      pdm_fall,
    output pdm_pair_t pair,
    output logic      step
);

    logic left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= 1'b0;
        end else if (en && pdm_rise) begin
            left_q <= pdm_dat;
        end
    end

    // A PDM period is complete once its right bit is present.
    assign step       = en && pdm_fall;
    assign pair.left  = left_q;
    assign pair.right = pdm_dat;

endmodule

// File: rtl/pdm_dec_phase.sv
module pdm_dec_phase #(
    parameter int S1_LO = 8,
    parameter int S1_HI = 16,
    parameter int S2_R  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    input  logic ratio_hi,
    output logic dump1,
    output logic s2_step,
    output logic dump2,
    output logic out_stb
);

    localparam int C1W = $clog2(S1_HI);
    localparam int C2W = (S2_R > 1) ? $clog2(S2_R) : 1;

    logic [C1W-1:0] cnt1;
    logic [C2W-1:0] cnt2;
    logic [C1W-1:0] lim1;

    assign lim1  = ratio_hi ? C1W'(S1_HI - 1) : C1W'(S1_LO - 1);
    assign dump1 = step && (cnt1 == lim1);
    assign dump2 = s2_step && (cnt2 == C2W'(S2_R - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt1    <= '0;
            cnt2    <= '0;
            s2_step <= 1'b0;
            out_stb <= 1'b0;
        end else begin
            if (step) begin
                cnt1 <= dump1 ? '0 : cnt1 + C1W'(1);
            end
            s2_step <= dump1;
            if (s2_step) begin
                cnt2 <= dump2 ? '0 : cnt2 + C2W'(1);
            end
            out_stb <= dump2;
        end
    end

endmodule

// File: rtl/cic3_stage.sv
module cic3_stage #(
    parameter int IN_W  = 2,
    parameter int ACC_W = 14
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    step,
    input  logic                    dump,
    input  logic signed [IN_W-1:0]  din,
    output logic signed [ACC_W-1:0] dout
);

    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] ig1, ig2, ig3;
    logic signed [ACC_W-1:0] dl1, dl2, dl3;
    logic signed [ACC_W-1:0] c1, c2, c3;

    assign x_ext = ACC_W'(din);

    // Comb section at the decimated rate, differential delay of one.
    assign c1 = ig3 - dl1;
    assign c2 = c1 - dl2;
    assign c3 = c2 - dl3;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ig1  <= '0;
            ig2  <= '0;
            ig3  <= '0;
            dl1  <= '0;
            dl2  <= '0;
            dl3  <= '0;
            dout <= '0;
        end else begin
            if (step) begin
                ig1 <= ig1 + x_ext;
                ig2 <= ig2 + ig1;
                ig3 <= ig3 + ig2;
            end
            if (dump) begin
                dl1  <= ig3;
                dl2  <= c1;
                dl3  <= c2;
                dout <= c3;
            end
        end
    end

endmodule

// File: rtl/pdm_stereo_decim.sv
module pdm_stereo_decim
    import pdm_dec_pkg::*;
#(
    parameter int S1_LO    = 8,
    parameter int S1_HI    = 16,
    parameter int S2_R     = 8,
    parameter int PCM_W    = 16,
    parameter int SKIP_OUT = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             pdm_dat,
    input  logic             pdm_rise,
    input  logic             pdm_fall,
    input  logic             ratio_sel,
    output logic [PCM_W-1:0] pcm_left,
    output logic [PCM_W-1:0] pcm_right,
    output logic             pcm_valid
);

    localparam int LOG_S1HI = $clog2(S1_HI);
    localparam int LOG_S1LO = $clog2(S1_LO);
    localparam int LOG_S2   = $clog2(S2_R);
    localparam int W1       = 2 + 3 * LOG_S1HI;
    localparam int W2       = W1 + 3 * LOG_S2;
    localparam int SH_HI    = pcm_shift(LOG_S1HI + LOG_S2, PCM_W);
    localparam int SH_LO    = pcm_shift(LOG_S1LO + LOG_S2, PCM_W);
    localparam int WMW      = $clog2(SKIP_OUT + 1);
    localparam logic signed [W2-1:0] HI_LIM = W2'((2 ** (PCM_W - 1)) - 1);
    localparam logic signed [W2-1:0] LO_LIM = -W2'(2 ** (PCM_W - 1));
    localparam logic signed [1:0] BIT_POS = 2'sb01;
    localparam logic signed [1:0] BIT_NEG = 2'sb11;

    function automatic logic [PCM_W-1:0] to_pcm(input logic signed [W2-1:0] v, input logic hi);
        logic signed [W2-1:0] s;
        s = hi ? (v >>> SH_HI) : (v >>> SH_LO);
        if (s > HI_LIM)      return HI_LIM[PCM_W-1:0];
        else if (s < LO_LIM) return LO_LIM[PCM_W-1:0];
        else                 return s[PCM_W-1:0];
    endfunction

    ratio_e    ratio_cfg;
    logic      ratio_q;
    logic      ratio_hi;
    logic      clr;
    pdm_pair_t pair;
    logic      step1, dump1, s2_step, dump2, out_stb;
    logic [1:0] ch_bit;
    logic [WMW-1:0] warm;
    logic signed [W1-1:0] s1_out [2];
    logic signed [W2-1:0] s2_out [2];

    assign ratio_cfg = ratio_e'(ratio_sel);
    assign ratio_hi  = (ratio_cfg == RATIO_128);
    assign clr       = !en || (ratio_sel != ratio_q);
    assign ch_bit    = {pair.right, pair.left};

    pdm_edge_split u_split (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .pdm_dat  (pdm_dat),
        .pdm_rise (pdm_rise),
        .pdm_fall (pdm_fall),
        .pair     (pair),
        .step     (step1)
    );

    pdm_dec_phase #(.S1_LO(S1_LO), .S1_HI(S1_HI), .S2_R(S2_R)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .step     (step1),
        .ratio_hi (ratio_hi),
        .dump1    (dump1),
        .s2_step  (s2_step),
        .dump2    (dump2),
        .out_stb  (out_stb)
    );

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        cic3_stage #(.IN_W(2), .ACC_W(W1)) u_s1 (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr),
            .step (step1),
            .dump (dump1),
            .din  (ch_bit[ch] ? BIT_POS : BIT_NEG),
            .dout (s1_out[ch])
        );
        cic3_stage #(.IN_W(W1), .ACC_W(W2)) u_s2 (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr),
            .step (s2_step),
            .dump (dump2),
            .din  (s1_out[ch]),
            .dout (s2_out[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q   <= 1'b0;
            warm      <= '0;
            pcm_left  <= '0;
            pcm_right <= '0;
            pcm_valid <= 1'b0;
        end else begin
            ratio_q   <= ratio_sel;
            pcm_valid <= 1'b0;
            if (clr) begin
                warm <= '0;
            end else if (out_stb) begin
                if (warm == WMW'(SKIP_OUT)) begin
                    pcm_left  <= to_pcm(s2_out[0], ratio_hi);
                    pcm_right <= to_pcm(s2_out[1], ratio_hi);
                    pcm_valid <= 1'b1;
                end else begin
                    warm <= warm + WMW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pdm_stereo_decim_chk.sv
module pdm_stereo_decim_chk #(
    parameter int S1_LO    = 8,
    parameter int S1_HI    = 16,
    parameter int S2_R     = 8,
    parameter int PCM_W    = 16,
    parameter int SKIP_OUT = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             pdm_fall,
    input logic             ratio_sel,
    input logic [PCM_W-1:0] pcm_left,
    input logic [PCM_W-1:0] pcm_right,
    input logic             pcm_valid
);

    localparam int FIRST_HI = (SKIP_OUT + 1) * S1_HI * S2_R;
    localparam int FIRST_LO = (SKIP_OUT + 1) * S1_LO * S2_R;
    localparam int CW       = $clog2(FIRST_HI + 1) + 1;

    logic          prev_ratio;
    logic [CW-1:0] periods;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ratio <= 1'b0;
            periods    <= '0;
        end else begin
            prev_ratio <= ratio_sel;
            if (!en || ratio_sel != prev_ratio) begin
                periods <= '0;
            end else if (pdm_fall && periods != '1) begin
                periods <= periods + CW'(1);
            end
        end
    end

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |=> !pcm_valid);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pcm_valid |-> ($stable(pcm_left) && $stable(pcm_right)));

    // R7
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !pcm_valid);

    // R6
    warmup_chk: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> (periods >= (ratio_sel ? CW'(FIRST_HI) : CW'(FIRST_LO))));

endmodule

bind pdm_stereo_decim pdm_stereo_decim_chk #(
    .S1_LO(S1_LO), .S1_HI(S1_HI), .S2_R(S2_R), .PCM_W(PCM_W), .SKIP_OUT(SKIP_OUT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .pdm_fall  (pdm_fall),
    .ratio_sel (ratio_sel),
    .pcm_left  (pcm_left),
    .pcm_right (pcm_right),
    .pcm_valid (pcm_valid)
);

// File: tb/tb_pdm_stereo_decim.sv
`timescale 1ns/1ps
module tb_pdm_stereo_decim;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        pdm_dat = 1'b0;
    logic        pdm_rise = 1'b0;
    logic        pdm_fall = 1'b0;
    logic        ratio_sel = 1'b0;
    logic [15:0] pcm_left;
    logic [15:0] pcm_right;
    logic        pcm_valid;

    always #2 clk = ~clk;

    pdm_stereo_decim dut (
        .clk(clk), .rst(rst), .en(en), .pdm_dat(pdm_dat),
        .pdm_rise(pdm_rise), .pdm_fall(pdm_fall), .ratio_sel(ratio_sel),
        .pcm_left(pcm_left), .pcm_right(pcm_right), .pcm_valid(pcm_valid)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit mon_on = 0;
    int pairs = 0;
    int vsince = 0;
    int first_at = -1;
    int last_gap = 0;
    int at_last = 0;
    int got_l = 0;
    int got_r = 0;
    int hold_err = 0;
    int width_err = 0;
    logic prev_v = 0;
    logic [15:0] held_l = '0;
    logic [15:0] held_r = '0;
    int bit_idx = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_dc(input logic [7:0] m);
        int v;
        v = (2 * $countones(m) - 8) * 4096;
        if (v > 32767) v = 32767;
        return v;
    endfunction

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (mon_on) begin
            if (pcm_valid) begin
                if (vsince == 0) first_at = pairs;
                else last_gap = pairs - at_last;
                at_last = pairs;
                vsince++;
                got_l = int'($signed(pcm_left));
                got_r = int'($signed(pcm_right));
                held_l = pcm_left;
                held_r = pcm_right;
                if (prev_v) width_err++;
            end else if (pcm_left != held_l || pcm_right != held_r) begin
                hold_err++;
            end
            prev_v = pcm_valid;
        end
    end

    task automatic pdm_bit(input logic l, input logic r);
        pdm_dat = l; pdm_rise = 1'b1;
        @(negedge clk); pdm_rise = 1'b0;
        repeat (3) @(negedge clk);
        pdm_dat = r; pdm_fall = 1'b1; pairs++;
        @(negedge clk); pdm_fall = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic mark();
        pairs = 0; vsince = 0; at_last = 0; first_at = -1;
    endtask

    task automatic run_outputs(input int n, input logic [7:0] ml, input logic [7:0] mr);
        int target;
        target = vsince + n;
        while (vsince < target) begin
            pdm_bit(ml[bit_idx % 8], mr[bit_idx % 8]);
            bit_idx++;
        end
    endtask

    task automatic dc_case(input logic sel, input logic [7:0] ml, input logic [7:0] mr, input string tag);
        if (ratio_sel != sel) begin
            ratio_sel = sel;
            mark();
        end
        run_outputs(6, ml, mr);
        check(got_l == exp_dc(ml), {tag, " R3 left"}, got_l, exp_dc(ml));
        check(got_r == exp_dc(mr), {tag, " R3 right"}, got_r, exp_dc(mr));
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        mon_on = 1;
        @(negedge clk);
        // R1: reset state
        check(pcm_left == 16'd0 && pcm_right == 16'd0, "R1 outputs after reset", int'(pcm_left), 0);
        check(pcm_valid == 1'b0, "R1 valid after reset", int'(pcm_valid), 0);

        // R7: strobes ignored while disabled
        ratio_sel = 1'b1;
        repeat (450) pdm_bit(1'b1, 1'b0);
        check(vsince == 0, "R7 no valid while disabled", vsince, 0);

        // R6, R2, R8, R4, R5: enable at ratio 128, left all ones, right all zeros
        mark();
        en = 1'b1;
        run_outputs(1, 8'hFF, 8'h00);
        check(first_at == 384, "R6 first valid at ratio 128", first_at, 384);
        run_outputs(7, 8'hFF, 8'h00);
        check(got_l == 32767, "R8 all ones saturates, left bit on rise R2", got_l, 32767);
        check(got_r == -32768, "R8 all zeros, right bit on fall R2", got_r, -32768);
        check(last_gap == 128, "R4 spacing at ratio 128", last_gap, 128);

        // R2: swapped contents
        run_outputs(6, 8'h00, 8'hFF);
        check(got_l == -32768, "R2 swapped left", got_l, -32768);
        check(got_r == 32767, "R2 swapped right", got_r, 32767);

        // R6, R4: ratio change to 64 while running
        ratio_sel = 1'b0;
        mark();
        run_outputs(1, 8'h55, 8'h0F);
        check(first_at == 192, "R6 first valid after change to 64", first_at, 192);
        run_outputs(6, 8'h55, 8'h0F);
        check(last_gap == 64, "R4 spacing at ratio 64", last_gap, 64);
        check(got_l == 0, "R3 half density left", got_l, 0);
        check(got_r == 0, "R3 half density right", got_r, 0);

        // R7, R6: enable drop clears and restarts warm-up
        en = 1'b0;
        mark();
        repeat (200) pdm_bit(1'b1, 1'b1);
        check(vsince == 0, "R7 no valid after enable drop", vsince, 0);
        mark();
        en = 1'b1;
        run_outputs(1, 8'h01, 8'hFE);
        check(first_at == 192, "R6 first valid after re-enable", first_at, 192);

        // Directed corner densities
        dc_case(1'b0, 8'h01, 8'hFE, "one-in-eight ratio 64");
        dc_case(1'b1, 8'h7F, 8'h80, "seven-in-eight ratio 128");

        // R3: random density patterns at both ratios
        for (int i = 0; i < 8; i++) begin
            logic [7:0] ml;
            logic [7:0] mr;
            ml = 8'($urandom);
            mr = 8'($urandom);
            dc_case((i % 3) == 2, ml, mr, "random");
        end

        // R5, R9: accumulated monitor results
        check(width_err == 0, "R5 valid one cycle wide", width_err, 0);
        check(hold_err == 0, "R9 outputs held between valids", hold_err, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule